// File: doc/BRIEF.md
# Multi-Range Frequency Meter

This block measures how often a single, already conditioned digital input toggles, and reports the result as an unsigned integer in hertz. It counts rising edges of the input over a gate window timed by an external one-millisecond tick. At the end of each window it converts the edge count into hertz and registers the value. The window length comes from a 2-bit range selector: a short window for fast signals, a long one for slow signals, and a middle one for automatic use.

The count is turned into hertz without a divider. Each range has a fixed fractional reciprocal of its gate length, so the conversion is one constant multiply and a shift. A separate idle guard watches the time since the last rising edge. If that time reaches a programmable limit, in milliseconds, the reading is forced to zero and stays there until edges return. Reset loads a nonzero default limit, and a write of zero to the limit is refused, so no path can leave the guard in a state where it forces zero all the time.

Top module: `freq_meter`

## Requirements
- R1: After reset, `freq_hz` is 0, `freq_valid` is 0, the active range is automatic and the idle limit is 1000 ms.
- R2: Only rising edges of `sig_in` are counted, as seen at consecutive clock edges. An input that is already high when reset is released does not count as an edge.
- R3: The gate length is 330 ms when `range_mode` is 0 (automatic), 1000 ms when it is 1 (low), 100 ms when it is 2 (high), and 330 ms when it is 3. A gate closes on its N-th `ms_tick`, where N is the gate length, counted from reset release, a range change or the previous gate close. `freq_valid` is high for exactly the one cycle after the closing tick.
- R4: At a gate close, `freq_hz` becomes (N_edges × S) >> 10. S is 3103 in automatic range, 1024 in low range and 10240 in high range. The edges counted include one that arrives in the closing cycle.
- R5: A change of `range_mode` restarts the gate timer and discards the edges counted so far in the current gate. No `freq_valid` is produced for the interrupted gate.
- R6: Once a number of `ms_tick`s equal to the idle limit has passed with no rising edge, `freq_hz` is forced to 0 one cycle later. Every gate that closes while in this state reports 0. The next rising edge leaves this state.
- R7: A pulse on `tmo_wr` with a nonzero `tmo_ms` loads that value as the idle limit. A pulse with `tmo_ms` = 0 is ignored, and the previous limit stays in force.
- R8: Between gate closes, `freq_hz` holds its value unless R6 forces it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sig_in | input | 1 | Conditioned, synchronous signal to be measured |
| range_mode | input | 2 | 0 automatic, 1 low, 2 high, 3 as automatic |
| tmo_wr | input | 1 | Load strobe for the idle limit |
| tmo_ms | input | 16 | New idle limit in ms; 0 is refused |
| freq_hz | output | 32 | Registered frequency reading in Hz |
| freq_valid | output | 1 | One-cycle pulse when a gate result is registered |

## Verification
The assertions check the following on every cycle:
- `freq_valid` never lasts longer than one cycle and only follows a millisecond tick.
- The gate position stays inside the active gate length.
- A range change always empties the edge counter.
- The idle limit never becomes zero, and a zero write leaves it unchanged.
- An idle state forces a zero reading.

Only the bench scenarios can show the following, which it checks against a model built from the requirements:
- The numeric readings for each range.
- The exact gate lengths.
- The handling of an input that is high at reset.
- The discarded partial gate after a range change.
- The idle limit actually in force, that is, the 1000 ms default and a refused zero write.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  localparam logic [1:0] RANGE_AUTO = 2'd0;
  localparam logic [1:0] RANGE_LOW  = 2'd1;
  localparam logic [1:0] RANGE_HIGH = 2'd2;

  // Rounded fixed-point reciprocal: 1000 * 2^frac / gate_ms
  function automatic int recip_scale(input int gate_ms, input int frac);
    return ((1000 << frac) + gate_ms / 2) / gate_ms;
  endfunction
endpackage

// File: rtl/freqm_gate.sv
module freqm_gate
  import freqm_pkg::*;
#(
  parameter int GATE_W       = 16,
  parameter int GATE_AUTO_MS = 330,
  parameter int GATE_LOW_MS  = 1000,
  parameter int GATE_HIGH_MS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic [1:0] range_mode,
  output logic [1:0] cur_mode,
  output logic       restart,
  output logic       gate_end
);
  logic [GATE_W-1:0] ms_q;
  logic [GATE_W-1:0] gate_len;

  always_comb begin
    case (cur_mode)
      RANGE_LOW:  gate_len = GATE_W'(GATE_LOW_MS);
      RANGE_HIGH: gate_len = GATE_W'(GATE_HIGH_MS);
      default:    gate_len = GATE_W'(GATE_AUTO_MS);
    endcase
  end

  assign restart  = (range_mode != cur_mode);
  assign gate_end = !restart && ms_tick && (ms_q == gate_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q     <= '0;
      cur_mode <= RANGE_AUTO;
    end else if (restart) begin
      ms_q     <= '0;
      cur_mode <= range_mode;
    end else if (ms_tick) begin
      ms_q <= gate_end ? '0 : ms_q + 1'b1;
    end
  end

  // R3
  gate_pos_chk: assert property (@(posedge clk) disable iff (rst)
    ms_q < gate_len);
endmodule

// File: rtl/freqm_edges.sv
module freqm_edges #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             restart,
  input  logic             gate_end,
  output logic             edge_o,
  output logic [CNT_W-1:0] total_o
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o  = sig_in & ~prev_q;
  assign total_o = cnt_q + CNT_W'(edge_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;  // a high level at reset release is not an edge
      cnt_q  <= '0;
    end else begin
      prev_q <= sig_in;
      if (restart || gate_end) cnt_q <= '0;
      else                     cnt_q <= total_o;
    end
  end

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/freqm_idle.sv
module freqm_idle #(
  parameter int TMO_W       = 16,
  parameter int TMO_DEFAULT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             edge_i,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_val,
  output logic             stale_o
);
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] idle_q;
  logic [TMO_W:0]   idle_next;

  assign idle_next = {1'b0, idle_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= TMO_W'(TMO_DEFAULT);
    end else if (tmo_wr && (tmo_val != '0)) begin
      tmo_q <= tmo_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= '0;
      stale_o <= 1'b0;
    end else if (edge_i) begin
      idle_q  <= '0;
      stale_o <= 1'b0;
    end else if (ms_tick) begin
      if (idle_q != '1) idle_q <= idle_next[TMO_W-1:0];
      if (idle_next >= {1'b0, tmo_q}) stale_o <= 1'b1;
    end
  end

  // R1
  tmo_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_q != '0);
  // R7
  tmo_zero_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_wr && tmo_val == '0) |=> $stable(tmo_q));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freqm_pkg::*;
#(
  parameter int GATE_AUTO_MS = 330,
  parameter int GATE_LOW_MS  = 1000,
  parameter int GATE_HIGH_MS = 100,
  parameter int TMO_W        = 16,
  parameter int TMO_DEFAULT  = 1000,
  parameter int CNT_W        = 32,
  parameter int OUT_W        = 32,
  parameter int FRAC         = 10,
  parameter int SCALE_W      = 16,
  parameter int GATE_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             sig_in,
  input  logic [1:0]       range_mode,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_ms,
  output logic [OUT_W-1:0] freq_hz,
  output logic             freq_valid
);
  localparam int SC_AUTO = recip_scale(GATE_AUTO_MS, FRAC);
  localparam int SC_LOW  = recip_scale(GATE_LOW_MS, FRAC);
  localparam int SC_HIGH = recip_scale(GATE_HIGH_MS, FRAC);
  localparam int PROD_W  = CNT_W + SCALE_W;

  logic [1:0]         cur_mode;
  logic               restart, gate_end, edge_w, stale;
  logic [CNT_W-1:0]   total;
  logic [SCALE_W-1:0] scale;
  logic [PROD_W-1:0]  prod;
  logic [OUT_W-1:0]   scaled;

  freqm_gate #(
    .GATE_W(GATE_W), .GATE_AUTO_MS(GATE_AUTO_MS),
    .GATE_LOW_MS(GATE_LOW_MS), .GATE_HIGH_MS(GATE_HIGH_MS)
  ) u_gate (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .range_mode(range_mode),
    .cur_mode(cur_mode), .restart(restart), .gate_end(gate_end)
  );

  freqm_edges #(.CNT_W(CNT_W)) u_edges (
    .clk(clk), .rst(rst), .sig_in(sig_in), .restart(restart),
    .gate_end(gate_end), .edge_o(edge_w), .total_o(total)
  );

  freqm_idle #(.TMO_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)) u_idle (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .edge_i(edge_w),
    .tmo_wr(tmo_wr), .tmo_val(tmo_ms), .stale_o(stale)
  );

  always_comb begin
    case (cur_mode)
      RANGE_LOW:  scale = SCALE_W'(SC_LOW);
      RANGE_HIGH: scale = SCALE_W'(SC_HIGH);
      default:    scale = SCALE_W'(SC_AUTO);
    endcase
  end

  assign prod   = PROD_W'(total) * PROD_W'(scale);
  assign scaled = prod[FRAC +: OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_hz    <= '0;
      freq_valid <= 1'b0;
    end else begin
      freq_valid <= gate_end;
      if (gate_end)   freq_hz <= stale ? '0 : scaled;
      else if (stale) freq_hz <= '0;
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    freq_valid |=> !freq_valid);
  // R3
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    freq_valid |-> $past(ms_tick));
  // R6
  stale_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stale && !gate_end) |=> (freq_hz == '0));
endmodule

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic        sig_in = 1'b0;
  logic [1:0]  range_mode = 2'd0;
  logic        tmo_wr = 1'b0;
  logic [15:0] tmo_ms = 16'd0;
  logic [31:0] freq_hz;
  logic        freq_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int sig_mode = 0;  // 0 low, 1 high, 2 toggling
  int hp = 5;

  freq_meter u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .sig_in(sig_in),
    .range_mode(range_mode), .tmo_wr(tmo_wr), .tmo_ms(tmo_ms),
    .freq_hz(freq_hz), .freq_valid(freq_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int gate_of(input logic [1:0] m);
    return (m == 2'd1) ? 1000 : (m == 2'd2) ? 100 : 330;
  endfunction

  function automatic logic [31:0] hz_of(input logic [1:0] m, input longint n);
    longint s;
    s = (m == 2'd1) ? 1024 : (m == 2'd2) ? 10240 : 3103;
    return 32'((n * s) >> 10);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus generators, driven away from the active edge
  int tdiv = 0;
  int ph = 0;
  always @(negedge clk) begin
    if (rst) begin tdiv = 0; ms_tick = 1'b0; end
    else begin
      tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      ms_tick = (tdiv == 0);
    end
    if (sig_mode == 0) sig_in = 1'b0;
    else if (sig_mode == 1) sig_in = 1'b1;
    else begin
      ph++;
      if (ph >= hp) begin ph = 0; sig_in = ~sig_in; end
    end
  end

  // reference model from the requirements
  logic        m_prev, m_valid, m_stale;
  logic [1:0]  m_mode;
  longint      m_cnt;
  int          m_ms, m_idle;
  int          m_tmo;
  logic [31:0] m_freq;
  always @(posedge clk) begin
    logic e, gend;
    longint tot;
    if (rst) begin
      m_prev = 1'b1; m_valid = 1'b0; m_stale = 1'b0; m_mode = 2'd0;
      m_cnt = 0; m_ms = 0; m_idle = 0; m_tmo = 1000; m_freq = 0;
    end else begin
      e = sig_in && !m_prev;
      m_prev = sig_in;
      gend = 1'b0;
      tot = m_cnt + e;
      if (range_mode != m_mode) begin
        m_mode = range_mode; m_ms = 0; m_cnt = 0;
      end else if (ms_tick && m_ms == gate_of(m_mode) - 1) begin
        gend = 1'b1; m_ms = 0; m_cnt = 0;
      end else begin
        if (ms_tick) m_ms++;
        m_cnt = tot;
      end
      m_valid = gend;
      if (gend) m_freq = m_stale ? 32'd0 : hz_of(m_mode, tot);
      else if (m_stale) m_freq = 32'd0;
      if (e) begin m_idle = 0; m_stale = 1'b0; end
      else if (ms_tick) begin
        if (m_idle < 65535) m_idle++;
        if (m_idle >= m_tmo) m_stale = 1'b1;
      end
      if (tmo_wr && tmo_ms != 0) m_tmo = tmo_ms;
    end
  end

  // continuous comparison at each update (R3, R4, R5, R8)
  always @(negedge clk) begin
    if (!rst && (freq_valid || m_valid)) begin
      chk(freq_valid == m_valid, "R3 valid timing", freq_valid, m_valid);
      chk(freq_hz == m_freq, "R4 reading at gate close", freq_hz, m_freq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_valid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!freq_valid);
  endtask

  task automatic wait_ms(input int ms);
    repeat (ms * TICK_DIV) @(negedge clk);
  endtask

  task automatic write_tmo(input int v);
    @(negedge clk); tmo_wr = 1'b1; tmo_ms = 16'(v);
    @(negedge clk); tmo_wr = 1'b0; tmo_ms = 16'd0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int n;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));

    // R1 / R2: reset with input held high
    sig_mode = 1;
    repeat (5) @(negedge clk);
    chk(freq_hz == 0, "R1 reset reading", freq_hz, 0);
    chk(freq_valid == 0, "R1 reset valid", freq_valid, 0);
    rst = 1'b0;
    wait_valid(n);
    chk(n >= 330 * TICK_DIV - TICK_DIV && n <= 330 * TICK_DIV + TICK_DIV,
        "R1 default automatic gate", n, 330 * TICK_DIV);
    chk(freq_hz == 0, "R2 high level at reset not counted", freq_hz, 0);

    // R4 directed readings, period 10 cycles
    sig_mode = 2; hp = 5;
    range_mode = 2'd2;
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 400, "R4 high range reading", freq_hz, 400);
    chk(n == 100 * TICK_DIV, "R3 high gate length", n, 100 * TICK_DIV);
    range_mode = 2'd0;
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 399, "R4 automatic range reading", freq_hz, 399);
    chk(n == 330 * TICK_DIV, "R3 automatic gate length", n, 330 * TICK_DIV);
    range_mode = 2'd1;
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 400, "R4 low range reading", freq_hz, 400);
    chk(n == 1000 * TICK_DIV, "R3 low gate length", n, 1000 * TICK_DIV);
    range_mode = 2'd3;
    wait_valid(n); wait_valid(n);
    chk(n == 330 * TICK_DIV, "R3 code 3 as automatic", n, 330 * TICK_DIV);

    // R5: change range mid-gate, partial gate discarded
    range_mode = 2'd2;
    wait_valid(n);
    wait_ms(40);
    range_mode = 2'd0;
    wait_valid(n);
    chk(n >= 330 * TICK_DIV - TICK_DIV && n <= 330 * TICK_DIV + TICK_DIV,
        "R5 restart after range change", n, 330 * TICK_DIV);
    chk(freq_hz == 399, "R5 full gate after restart", freq_hz, 399);

    // random phases (model compares each result)
    for (int k = 0; k < 8; k++) begin
      hp = 2 + int'($urandom % 20);
      range_mode = 2'($urandom % 4);
      wait_valid(n); wait_valid(n);
    end

    // R6 / R7: shorter idle limit
    hp = 5; range_mode = 2'd2;
    write_tmo(20);
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 400, "R6 reading before idle", freq_hz, 400);
    sig_mode = 0;
    wait_ms(30);
    chk(freq_hz == 0, "R6 forced zero after idle limit", freq_hz, 0);
    chk(freq_hz == m_freq, "R6 model agrees", freq_hz, m_freq);
    sig_mode = 2;
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 400, "R6 edges resume", freq_hz, 400);

    // R7: zero write refused, limit stays 20
    write_tmo(0);
    wait_valid(n);
    sig_mode = 0;
    wait_ms(10);
    chk(freq_hz == 400, "R7 zero limit ignored (R8 hold)", freq_hz, 400);
    wait_ms(15);
    chk(freq_hz == 0, "R7 previous limit still active", freq_hz, 0);

    // R1: default limit of 1000 ms after reset
    sig_mode = 2; hp = 5; range_mode = 2'd1;
    do_reset();
    wait_valid(n); wait_valid(n);
    chk(freq_hz == 400, "R1 low range after reset", freq_hz, 400);
    wait_ms(10);
    sig_mode = 0;
    wait_valid(n);
    chk(freq_hz != 0, "R1 default limit above 990 ms", freq_hz, m_freq);
    chk(freq_hz == m_freq, "R4 partial gate reading", freq_hz, m_freq);
    wait_ms(25);
    chk(freq_hz == 0, "R1 default limit reached near 1000 ms", freq_hz, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule